// File: doc/BRIEF.md
# UART Loop-back Diagnostic Router

This block sits between a UART core and its package pins and decides where the serial and modem-handshake signals go. In normal operation it passes the receive pin and the four active-low modem-status pins into the core as active-high signals. It also drives the transmit pin from the serializer and drives the four active-low modem-control pins from the control register bits.

When the diagnostic self-test bit is set, the block cuts the core off from the pins. The serializer output feeds the deserializer input directly. The four modem-status inputs of the core are fed from the four low modem-control bits, so software can move every status line and see the resulting change indications. The transmit pin idles at mark and the modem-control pins sit at their inactive level. Interrupt logic downstream is untouched: it sees ordinary status and serial activity and stays gated by its own enable register.

The mode bit is captured on a clock edge. Every routed output switches together, one clean cycle after the bit is sampled, so the change detectors in the status logic see a single transition.

Top module: `uart_loopback_router`

## Requirements
- R1: After a synchronous reset, `loop_active` is 0 and the block routes in normal mode.
- R2: In normal mode, `core_rx` equals `rx_pin` and `tx_pin` equals `core_tx`.
- R3: In normal mode, each bit of `msr_in` is the inverse of the same bit of `mdm_n` (bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD).
- R4: In normal mode, each bit of `ctl_n` is the inverse of the same bit of `mcr_low` (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2).
- R5: In loop-back mode, `core_rx` equals `core_tx` in the same cycle, `tx_pin` is held at 1, and `rx_pin` has no effect.
- R6: In loop-back mode, CTS (`msr_in[0]`) follows DTR (`mcr_low[0]`) and DSR (`msr_in[1]`) follows RTS (`mcr_low[1]`).
- R7: In loop-back mode, RI (`msr_in[2]`) follows OUT1 (`mcr_low[2]`) and DCD (`msr_in[3]`) follows OUT2 (`mcr_low[3]`).
- R8: In loop-back mode, the `mdm_n` pins have no effect on `msr_in`.
- R9: In loop-back mode, all four `ctl_n` outputs are held at 1 (inactive).
- R10: A change of `loop_en` takes effect only at the next rising clock edge. From that edge, `loop_active` and all routed outputs reflect the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | Loop-back request bit from the modem-control register |
| mcr_low | input | 4 | Modem-control bits: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 (active-high) |
| core_tx | input | 1 | Serializer output from the UART core |
| rx_pin | input | 1 | Receive data pin |
| mdm_n | input | 4 | Modem-status pins, active-low: 0 CTS, 1 DSR, 2 RI, 3 DCD |
| core_rx | output | 1 | Serial input to the deserializer |
| tx_pin | output | 1 | Transmit data pin |
| msr_in | output | 4 | Active-high modem-status to the core, same bit order as `mdm_n` |
| ctl_n | output | 4 | Modem-control pins, active-low, same bit order as `mcr_low` |
| loop_active | output | 1 | Registered loop-back mode flag |

## Verification
The vector walk sets alternating and complementary bit patterns on `mcr_low` and `mdm_n`, with the two patterns deliberately different from each other. A swapped cross-wire, a missing inversion or a mux that picks the wrong source therefore shows up as a wrong bit in `msr_in` or `ctl_n`. The same vectors are replayed in both modes with opposite levels on `rx_pin` and `core_tx`, which separates the internal serial loop from plain pass-through and shows that the transmit pin holds at mark. Directed steps then toggle the external pins while in loop-back to show they are ignored. They also sample just before and just after the capturing edge, which tells a registered mode switch from a combinational one.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    localparam int MDM_W = 4;

    // status bit positions (core side and pin side)
    localparam int ST_CTS = 0;
    localparam int ST_DSR = 1;
    localparam int ST_RI  = 2;
    localparam int ST_DCD = 3;

    // control bit positions
    localparam int CT_DTR  = 0;
    localparam int CT_RTS  = 1;
    localparam int CT_OUT1 = 2;
    localparam int CT_OUT2 = 3;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } lb_mode_e;

    typedef struct packed {
        logic                 ser;
        logic [MDM_W-1:0]     mdm;
    } lb_side_t;

    // which control bit feeds a given status bit in loop-back
    function automatic int loop_src(input int st);
        case (st)
            ST_CTS:  return CT_DTR;
            ST_DSR:  return CT_RTS;
            ST_RI:   return CT_OUT1;
            default: return CT_OUT2;
        endcase
    endfunction

    // active-low pin level to active-high internal level
    function automatic logic pin_to_int(input logic p);
        return ~p;
    endfunction

    // active-high internal level to active-low pin level
    function automatic logic int_to_pin(input logic v);
        return ~v;
    endfunction

endpackage

// File: rtl/lb_mode_reg.sv
module lb_mode_reg
    import uart_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     loop_req,
    output lb_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_NORMAL;
        end else begin
            mode_q <= loop_req ? MODE_LOOP : MODE_NORMAL;
        end
    end

    // R10
    mode_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((mode_q == MODE_LOOP) == $past(loop_req)));

endmodule

// File: rtl/lb_serial_route.sv
module lb_serial_route
    import uart_lb_pkg::*;
(
    input  lb_mode_e mode,
    input  logic     core_tx,
    input  logic     rx_pin,
    output logic     core_rx,
    output logic     tx_pin
);

    localparam logic MARK = 1'b1;

    always_comb begin
        if (mode == MODE_LOOP) begin
            core_rx = core_tx;
            tx_pin  = MARK;
        end else begin
            core_rx = rx_pin;
            tx_pin  = core_tx;
        end
    end

endmodule

// File: rtl/lb_modem_route.sv
module lb_modem_route
    import uart_lb_pkg::*;
#(
    parameter int W = MDM_W
) (
    input  lb_mode_e       mode,
    input  logic [W-1:0]   mcr_low,
    input  logic [W-1:0]   mdm_n,
    output logic [W-1:0]   msr_in,
    output logic [W-1:0]   ctl_n
);

    localparam logic INACTIVE_PIN = 1'b1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        localparam int SRC = loop_src(g);

        always_comb begin
            if (mode == MODE_LOOP) begin
                msr_in[g] = mcr_low[SRC];
                ctl_n[g]  = INACTIVE_PIN;
            end else begin
                msr_in[g] = pin_to_int(mdm_n[g]);
                ctl_n[g]  = int_to_pin(mcr_low[g]);
            end
        end
    end

endmodule

// File: rtl/uart_loopback_router.sv
module uart_loopback_router
    import uart_lb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             loop_en,
    input  logic [MDM_W-1:0] mcr_low,
    input  logic             core_tx,
    input  logic             rx_pin,
    input  logic [MDM_W-1:0] mdm_n,
    output logic             core_rx,
    output logic             tx_pin,
    output logic [MDM_W-1:0] msr_in,
    output logic [MDM_W-1:0] ctl_n,
    output logic             loop_active
);

    lb_mode_e mode;
    lb_side_t core_side;

    lb_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .loop_req (loop_en),
        .mode_q   (mode)
    );

    lb_serial_route u_ser (
        .mode    (mode),
        .core_tx (core_tx),
        .rx_pin  (rx_pin),
        .core_rx (core_side.ser),
        .tx_pin  (tx_pin)
    );

    lb_modem_route #(.W(MDM_W)) u_mdm (
        .mode    (mode),
        .mcr_low (mcr_low),
        .mdm_n   (mdm_n),
        .msr_in  (core_side.mdm),
        .ctl_n   (ctl_n)
    );

    assign core_rx     = core_side.ser;
    assign msr_in      = core_side.mdm;
    assign loop_active = (mode == MODE_LOOP);

    // R1
    reset_normal_chk: assert property (@(posedge clk)
        $past(rst) |-> !loop_active);

    // R2
    normal_serial_chk: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> (core_rx == rx_pin && tx_pin == core_tx));

    // R3
    normal_status_chk: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> (msr_in == ~mdm_n));

    // R4
    normal_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> (ctl_n == ~mcr_low));

    // R5
    loop_serial_chk: assert property (@(posedge clk) disable iff (rst)
        loop_active |-> (core_rx == core_tx && tx_pin));

    // R6 R7
    loop_status_chk: assert property (@(posedge clk) disable iff (rst)
        loop_active |-> (msr_in[ST_CTS] == mcr_low[CT_DTR] &&
                         msr_in[ST_DSR] == mcr_low[CT_RTS] &&
                         msr_in[ST_RI]  == mcr_low[CT_OUT1] &&
                         msr_in[ST_DCD] == mcr_low[CT_OUT2]));

    // R9
    loop_ctl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        loop_active |-> (&ctl_n));

endmodule

// File: tb/tb_uart_loopback_router.sv
module tb_uart_loopback_router;

    localparam int CLK_P = 10;
    localparam int NV    = 8;

    // {loop, mcr[3:0], mdm_n[3:0], rx_pin, core_tx, exp_rx, exp_tx, exp_msr[3:0], exp_ctl[3:0]}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111},
        {1'b0, 4'b0101, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1001, 4'b1010},
        {1'b0, 4'b1010, 4'b1001, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, 4'b0101},
        {1'b1, 4'b0101, 4'b0110, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0101, 4'b1111},
        {1'b1, 4'b1010, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1010, 4'b1111},
        {1'b1, 4'b0001, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0001, 4'b1111},
        {1'b1, 4'b1110, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1110, 4'b1111},
        {1'b0, 4'b1100, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1100, 4'b0011}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       loop_en;
    logic [3:0] mcr_low;
    logic       core_tx;
    logic       rx_pin;
    logic [3:0] mdm_n;
    logic       core_rx;
    logic       tx_pin;
    logic [3:0] msr_in;
    logic [3:0] ctl_n;
    logic       loop_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_loopback_router dut (
        .clk         (clk),
        .rst         (rst),
        .loop_en     (loop_en),
        .mcr_low     (mcr_low),
        .core_tx     (core_tx),
        .rx_pin      (rx_pin),
        .mdm_n       (mdm_n),
        .core_rx     (core_rx),
        .tx_pin      (tx_pin),
        .msr_in      (msr_in),
        .ctl_n       (ctl_n),
        .loop_active (loop_active)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; loop_en = 1'b1; mcr_low = 4'b0000; core_tx = 1'b1;
        rx_pin = 1'b0; mdm_n = 4'b1111;
        step(); step();
        // R1: reset holds normal even with loop requested
        check("R1 loop_active in reset", {3'b0, loop_active}, 4'b0000);
        check("R1 rx passthrough in reset", {3'b0, core_rx}, 4'b0000);
        @(negedge clk);
        rst = 1'b0; loop_en = 1'b0;
        step();
        check("R1 loop_active after reset", {3'b0, loop_active}, 4'b0000);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            string sfx;
            v = VEC[i];
            @(negedge clk);
            loop_en = v[20]; mcr_low = v[19:16]; mdm_n = v[15:12];
            rx_pin = v[11]; core_tx = v[10];
            step();
            sfx = $sformatf(" vec%0d", i);
            check({v[20] ? "R5" : "R2", " core_rx", sfx}, {3'b0, core_rx}, {3'b0, v[9]});
            check({v[20] ? "R5" : "R2", " tx_pin", sfx}, {3'b0, tx_pin}, {3'b0, v[8]});
            check({v[20] ? "R6 R7" : "R3", " msr_in", sfx}, msr_in, v[7:4]);
            check({v[20] ? "R9" : "R4", " ctl_n", sfx}, ctl_n, v[3:0]);
            check({"R10 loop_active", sfx}, {3'b0, loop_active}, {3'b0, v[20]});
        end

        // R10: entering loop waits for the edge
        @(negedge clk);
        loop_en = 1'b0; mcr_low = 4'b0011; mdm_n = 4'b1111; rx_pin = 1'b0; core_tx = 1'b1;
        step();
        @(negedge clk);
        loop_en = 1'b1;
        #1;
        check("R10 before edge msr_in", msr_in, 4'b0000);
        check("R10 before edge tx_pin", {3'b0, tx_pin}, 4'b0001);
        check("R10 before edge core_rx", {3'b0, core_rx}, 4'b0000);
        step();
        check("R10 after edge msr_in", msr_in, 4'b0011);
        check("R10 after edge core_rx", {3'b0, core_rx}, 4'b0001);

        // R8 / R5: pins ignored in loop, serial loop live within the cycle
        @(negedge clk);
        mdm_n = 4'b0000; rx_pin = 1'b1; core_tx = 1'b0;
        #1;
        check("R8 msr_in with pins toggled", msr_in, 4'b0011);
        check("R5 core_rx follows core_tx", {3'b0, core_rx}, 4'b0000);
        check("R5 tx_pin held at mark", {3'b0, tx_pin}, 4'b0001);
        mdm_n = 4'b1010;
        #1;
        check("R8 msr_in with pins toggled again", msr_in, 4'b0011);
        // R6: single bit walk
        mcr_low = 4'b0001;
        #1;
        check("R6 DTR to CTS only", msr_in, 4'b0001);
        mcr_low = 4'b0010;
        #1;
        check("R6 RTS to DSR only", msr_in, 4'b0010);
        // R7
        mcr_low = 4'b0100;
        #1;
        check("R7 OUT1 to RI only", msr_in, 4'b0100);
        mcr_low = 4'b1000;
        #1;
        check("R7 OUT2 to DCD only", msr_in, 4'b1000);
        check("R9 ctl_n idle", ctl_n, 4'b1111);

        // R10: leaving loop waits for the edge
        loop_en = 1'b0;
        #1;
        check("R10 still loop before edge", {3'b0, loop_active}, 4'b0001);
        step();
        check("R10 normal after edge", {3'b0, loop_active}, 4'b0000);
        check("R3 msr_in after exit", msr_in, 4'b0101);
        check("R4 ctl_n after exit", ctl_n, 4'b0111);
        check("R2 core_rx after exit", {3'b0, core_rx}, 4'b0001);
        check("R2 tx_pin after exit", {3'b0, tx_pin}, 4'b0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule